// File: doc/BRIEF.md
# Lockstep Comparator with Built-in Self-Test

The block compares two N-bit buses driven by a pair of redundant processors running in lockstep. While it is idle it raises a registered compare-error output whenever the two buses differ. A start input launches a self-test. The self-test cuts the functional buses off from the comparator and drives generated vectors into both comparator inputs. It then checks the comparator's verdict on every cycle.

The self-test has two phases. The first is a match phase of four identical vector pairs, where the comparator must report agreement. The second is a walking-bit phase of 2N steps, where exactly one bit differs between the two inputs and the comparator must report a difference. The first wrong verdict ends the test. It sets a sticky fail flag and fires a one-cycle fail pulse. A done pulse marks the end of every test, whether it passed or failed.

A library parameter can select a comparator variant with a modelled defect: either one bit position that the comparator cannot see, or one bit position that always reads as different. These variants are used to qualify the self-test sequence itself.

Top module: `lockstep_cmp_bist`

## Requirements
- R1: While `bist_busy` is low, `cmp_err` in the next cycle equals 1 if `core_a` differs from `core_b` in any bit, else 0 (healthy comparator).
- R2: A high `bist_start` while idle makes `bist_busy` high from the next cycle. A `bist_start` while busy is ignored and does not restart or lengthen the test.
- R3: The match phase lasts four cycles and feeds both inputs the same vector, in this order: all ones, all zeros, odd bit positions set (0xA per nibble), even bit positions set (0x5 per nibble).
- R4: The walking phase has 2N steps. Step k < N clears bit k on input A with B all ones. Step k >= N clears bit k-N on input B with A all ones. Exactly one bit differs in each step.
- R5: A wrong verdict (a mismatch in the match phase, or agreement in the walking phase) ends the test in that cycle. The next cycle shows `bist_done`, `bist_fail_pulse` and `bist_fail_flag` high and `bist_busy` low.
- R6: A passing test shows `bist_done` exactly 4+2N cycles after the edge that took the start. `bist_done` is a one-cycle pulse, and `bist_fail_pulse` stays low.
- R7: `cmp_err` stays low in every cycle that follows a busy cycle, whatever `core_a` and `core_b` carry. Expected mismatches never reach it.
- R8: `bist_fail_flag` stays set until `bist_clear` is high at a clock edge or reset is applied. A new failure in the same cycle as a clear wins.
- R9: Functional comparison resumes in the cycle where `bist_done` is high. A difference in that cycle appears on `cmp_err` one cycle later.
- R10: With `FAULT_KIND`=1 (blind bit `FAULT_BIT`), the test fails at walking step `FAULT_BIT`, so done comes 5+`FAULT_BIT` cycles after start. With `FAULT_KIND`=2 (bit always different), it fails on the first match vector, so done comes 1 cycle after start.
- R11: During and after reset, all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| core_a | input | N | Bus from the first processor |
| core_b | input | N | Bus from the second processor |
| bist_start | input | 1 | Launches a self-test when idle |
| bist_clear | input | 1 | Clears the sticky fail flag |
| cmp_err | output | 1 | Registered functional compare error |
| bist_busy | output | 1 | Self-test running |
| bist_done | output | 1 | One-cycle end-of-test pulse |
| bist_fail_flag | output | 1 | Sticky self-test failure |
| bist_fail_pulse | output | 1 | One-cycle self-test failure pulse |

## Verification
The hardest situation to reach is a self-test failure. With a healthy comparator it cannot occur, and the test vectors cannot be reached from the ports. The bench therefore instantiates the block three times on the same stimulus: once healthy, once with a blind bit, and once with a bit that always mismatches. This drives both the walking-phase and match-phase failure paths. The time from start to done shows which step failed. During the runs the functional buses carry differing data and extra start pulses, so the bench can show that both are ignored.

// File: rtl/lsc_pkg.sv
package lsc_pkg;
   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_MATCH = 2'd1,
      ST_WALK  = 2'd2
   } lsc_state_e;

   localparam int MATCH_VECS = 4;
endpackage

// File: rtl/lsc_pattern_gen.sv
module lsc_pattern_gen
   import lsc_pkg::*;
#(
   parameter int N  = 32,
   parameter int IW = 6
) (
   input  logic          clk,
   input  logic          rst_n,
   input  lsc_state_e    state,
   input  logic [IW-1:0] idx,
   output logic [N-1:0]  vec_a,
   output logic [N-1:0]  vec_b
);
   localparam logic [IW-1:0] SEL_ONES  = IW'(0);
   localparam logic [IW-1:0] SEL_ZEROS = IW'(1);
   localparam logic [IW-1:0] SEL_ODD   = IW'(2);

   for (genvar i = 0; i < N; i++) begin : g_bit
      localparam logic ODD = (i % 2) == 1;
      localparam logic [IW-1:0] POS_A = IW'(i);
      localparam logic [IW-1:0] POS_B = IW'(N + i);
      logic pat;
      assign pat = (idx == SEL_ONES)  ? 1'b1 :
                   (idx == SEL_ZEROS) ? 1'b0 :
                   (idx == SEL_ODD)   ? ODD  : !ODD;
      assign vec_a[i] = (state == ST_MATCH) ? pat :
                        (state == ST_WALK)  ? (idx != POS_A) : 1'b0;
      assign vec_b[i] = (state == ST_MATCH) ? pat :
                        (state == ST_WALK)  ? (idx != POS_B) : 1'b0;
   end

   // R3
   match_equal_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_MATCH) |-> (vec_a == vec_b));

   // R4
   walk_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_WALK) |-> ($countones(vec_a ^ vec_b) == 1));
endmodule

// File: rtl/lsc_comparator.sv
module lsc_comparator #(
   parameter int N          = 32,
   parameter int FAULT_KIND = 0,
   parameter int FAULT_BIT  = 0
) (
   input  logic [N-1:0] in_x,
   input  logic [N-1:0] in_y,
   output logic         mis
);
   localparam logic [N-1:0] MASK = N'(1) << FAULT_BIT;
   logic [N-1:0] diff;

   if (FAULT_KIND == 1) begin : g_blind
      assign diff = (in_x ^ in_y) & ~MASK;
   end else if (FAULT_KIND == 2) begin : g_stuck
      assign diff = (in_x ^ in_y) | MASK;
   end else begin : g_healthy
      assign diff = in_x ^ in_y;
   end

   assign mis = |diff;
endmodule

// File: rtl/lsc_sequencer.sv
module lsc_sequencer
   import lsc_pkg::*;
#(
   parameter int N  = 32,
   parameter int IW = 6
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start,
   input  logic          clear,
   input  logic          mis,
   output lsc_state_e    state,
   output logic [IW-1:0] idx,
   output logic          busy,
   output logic          done,
   output logic          fail_flag,
   output logic          fail_pulse
);
   localparam logic [IW-1:0] MATCH_LAST = IW'(MATCH_VECS - 1);
   localparam logic [IW-1:0] WALK_LAST  = IW'(2 * N - 1);

   logic fail_now;
   logic pass_now;

   always_comb begin
      fail_now = 1'b0;
      pass_now = 1'b0;
      case (state)
         ST_MATCH: fail_now = mis;
         ST_WALK: begin
            fail_now = !mis;
            pass_now = mis && (idx == WALK_LAST);
         end
         default: ;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state      <= ST_IDLE;
         idx        <= '0;
         done       <= 1'b0;
         fail_pulse <= 1'b0;
      end else begin
         done       <= fail_now || pass_now;
         fail_pulse <= fail_now;
         if (fail_now || pass_now) begin
            state <= ST_IDLE;
            idx   <= '0;
         end else begin
            case (state)
               ST_IDLE: if (start) begin
                  state <= ST_MATCH;
                  idx   <= '0;
               end
               ST_MATCH: if (idx == MATCH_LAST) begin
                  state <= ST_WALK;
                  idx   <= '0;
               end else begin
                  idx <= idx + 1'b1;
               end
               ST_WALK: idx <= idx + 1'b1;
               default: state <= ST_IDLE;
            endcase
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        fail_flag <= 1'b0;
      else if (fail_now) fail_flag <= 1'b1;
      else if (clear)    fail_flag <= 1'b0;
   end

   assign busy = (state != ST_IDLE);

   // R5
   pulse_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
      fail_pulse |-> (done && fail_flag && $past(busy)));

   // R8
   flag_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (fail_flag && !clear) |=> fail_flag);
endmodule

// File: rtl/lockstep_cmp_bist.sv
module lockstep_cmp_bist
   import lsc_pkg::*;
#(
   parameter int N          = 32,
   parameter int FAULT_KIND = 0,
   parameter int FAULT_BIT  = 0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] core_a,
   input  logic [N-1:0] core_b,
   input  logic         bist_start,
   input  logic         bist_clear,
   output logic         cmp_err,
   output logic         bist_busy,
   output logic         bist_done,
   output logic         bist_fail_flag,
   output logic         bist_fail_pulse
);
   localparam int IW = ($clog2(2 * N) < 2) ? 2 : $clog2(2 * N);

   if (N < 1) begin : g_bad_width
      $error("lockstep_cmp_bist: N must be at least 1");
   end
   if (FAULT_KIND < 0 || FAULT_KIND > 2) begin : g_bad_kind
      $error("lockstep_cmp_bist: FAULT_KIND must be 0, 1 or 2");
   end
   if (FAULT_BIT < 0 || FAULT_BIT >= N) begin : g_bad_bit
      $error("lockstep_cmp_bist: FAULT_BIT out of range");
   end

   lsc_state_e    state;
   logic [IW-1:0] idx;
   logic [N-1:0]  vec_a, vec_b;
   logic [N-1:0]  cmp_x, cmp_y;
   logic          mis;

   lsc_pattern_gen #(.N(N), .IW(IW)) u_pat (
      .clk   (clk),
      .rst_n (rst_n),
      .state (state),
      .idx   (idx),
      .vec_a (vec_a),
      .vec_b (vec_b)
   );

   assign cmp_x = bist_busy ? vec_a : core_a;
   assign cmp_y = bist_busy ? vec_b : core_b;

   lsc_comparator #(.N(N), .FAULT_KIND(FAULT_KIND), .FAULT_BIT(FAULT_BIT)) u_cmp (
      .in_x (cmp_x),
      .in_y (cmp_y),
      .mis  (mis)
   );

   lsc_sequencer #(.N(N), .IW(IW)) u_seq (
      .clk        (clk),
      .rst_n      (rst_n),
      .start      (bist_start),
      .clear      (bist_clear),
      .mis        (mis),
      .state      (state),
      .idx        (idx),
      .busy       (bist_busy),
      .done       (bist_done),
      .fail_flag  (bist_fail_flag),
      .fail_pulse (bist_fail_pulse)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cmp_err <= 1'b0;
      else        cmp_err <= !bist_busy && mis;
   end

   // R7
   busy_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      bist_busy |=> !cmp_err);

   // R6
   done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      bist_done |-> !bist_busy);

   if (FAULT_KIND == 0) begin : g_func_chk
      // R1
      func_diff_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (!bist_busy && core_a != core_b) |=> cmp_err);
      // R1
      func_same_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (!bist_busy && core_a == core_b) |=> !cmp_err);
   end
endmodule

// File: tb/sim_lockstep_cmp_bist.sv
module sim_lockstep_cmp_bist;
   localparam int N  = 16;
   localparam int FB = 5;
   localparam int NI = 3;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic [N-1:0] a = '0, b = '0;
   logic start = 1'b0, clr = 1'b0;
   logic err_o[NI], busy_o[NI], done_o[NI], flag_o[NI], pulse_o[NI];

   always #5 clk = ~clk;

   lockstep_cmp_bist #(.N(N), .FAULT_KIND(0), .FAULT_BIT(0)) u0 (
      .clk(clk), .rst_n(rst_n), .core_a(a), .core_b(b), .bist_start(start), .bist_clear(clr),
      .cmp_err(err_o[0]), .bist_busy(busy_o[0]), .bist_done(done_o[0]),
      .bist_fail_flag(flag_o[0]), .bist_fail_pulse(pulse_o[0]));
   lockstep_cmp_bist #(.N(N), .FAULT_KIND(1), .FAULT_BIT(FB)) u1 (
      .clk(clk), .rst_n(rst_n), .core_a(a), .core_b(b), .bist_start(start), .bist_clear(clr),
      .cmp_err(err_o[1]), .bist_busy(busy_o[1]), .bist_done(done_o[1]),
      .bist_fail_flag(flag_o[1]), .bist_fail_pulse(pulse_o[1]));
   lockstep_cmp_bist #(.N(N), .FAULT_KIND(2), .FAULT_BIT(FB)) u2 (
      .clk(clk), .rst_n(rst_n), .core_a(a), .core_b(b), .bist_start(start), .bist_clear(clr),
      .cmp_err(err_o[2]), .bist_busy(busy_o[2]), .bist_done(done_o[2]),
      .bist_fail_flag(flag_o[2]), .bist_fail_pulse(pulse_o[2]));

   int checks = 0, errors = 0, cyc = 0;
   int fail_step[NI];
   bit m_busy[NI], m_done[NI], m_flag[NI], m_pulse[NI], m_err[NI];
   int m_step[NI];
   int done_at[NI];

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual %0d expected %0d (t=%0t)", tag, act, exp, $time);
      end
   endtask

   function automatic bit fmis(input int k, input logic [N-1:0] x, input logic [N-1:0] y);
      logic [N-1:0] m;
      m = N'(1) << FB;
      if (k == 1) return ((x ^ y) & ~m) != '0;
      if (k == 2) return 1'b1;
      return x != y;
   endfunction

   initial begin
      fail_step[0] = -1;
      fail_step[1] = 4 + FB;
      fail_step[2] = 0;
   end

   // behavioural reference, advanced on every rising edge
   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int k = 0; k < NI; k++) begin
            m_busy[k] = 0; m_done[k] = 0; m_flag[k] = 0; m_pulse[k] = 0;
            m_err[k] = 0; m_step[k] = 0;
         end
      end else begin
         cyc++;
         for (int k = 0; k < NI; k++) begin
            bit fail, fin;
            m_err[k] = !m_busy[k] && fmis(k, a, b);
            fail = m_busy[k] && (m_step[k] == fail_step[k]);
            fin  = m_busy[k] && (m_step[k] == 4 + 2 * N - 1);
            m_done[k]  = fail || fin;
            m_pulse[k] = fail;
            if (fail) m_flag[k] = 1;
            else if (clr) m_flag[k] = 0;
            if (fail || fin) m_busy[k] = 0;
            else if (m_busy[k]) m_step[k]++;
            else if (start) begin m_busy[k] = 1; m_step[k] = 0; end
         end
      end
   end

   // per-cycle comparison away from the active edge
   always @(negedge clk) begin
      if (rst_n) begin
         for (int k = 0; k < NI; k++) begin
            chk(err_o[k] == m_err[k], $sformatf("R1/R7/R9 cmp_err u%0d", k), int'(err_o[k]), int'(m_err[k]));
            chk(busy_o[k] == m_busy[k], $sformatf("R2 busy u%0d", k), int'(busy_o[k]), int'(m_busy[k]));
            chk(done_o[k] == m_done[k], $sformatf("R6 done u%0d", k), int'(done_o[k]), int'(m_done[k]));
            chk(flag_o[k] == m_flag[k], $sformatf("R8 flag u%0d", k), int'(flag_o[k]), int'(m_flag[k]));
            chk(pulse_o[k] == m_pulse[k], $sformatf("R5 pulse u%0d", k), int'(pulse_o[k]), int'(m_pulse[k]));
            if (done_o[k] && done_at[k] < 0) done_at[k] = cyc;
         end
      end
   end

   task automatic run_test(input bit extra_starts);
      int s_edge;
      for (int k = 0; k < NI; k++) done_at[k] = -1;
      @(negedge clk); start = 1;
      @(negedge clk); start = 0;
      s_edge = cyc;
      for (int i = 0; i < 4 + 2 * N + 4; i++) begin
         a = N'(16'hA5C3 ^ (i * 97));
         b = ~a;
         if (extra_starts && (i == 3 || i == 20)) start = 1;
         @(negedge clk); start = 0;
      end
      chk(done_at[0] - s_edge == 4 + 2 * N, "R6 pass latency", done_at[0] - s_edge, 4 + 2 * N);
      chk(done_at[1] - s_edge == 5 + FB, "R10 blind-bit latency (R4 walk order)", done_at[1] - s_edge, 5 + FB);
      chk(done_at[2] - s_edge == 1, "R10 stuck-bit latency (R3 first vector)", done_at[2] - s_edge, 1);
      chk(flag_o[0] == 0, "R6 healthy flag", int'(flag_o[0]), 0);
      chk(flag_o[1] == 1, "R5 blind flag", int'(flag_o[1]), 1);
      chk(flag_o[2] == 1, "R5 stuck flag", int'(flag_o[2]), 1);
   endtask

   initial begin
      for (int k = 0; k < NI; k++) done_at[k] = -1;
      repeat (3) @(negedge clk);
      for (int k = 0; k < NI; k++) begin
         chk({err_o[k], busy_o[k], done_o[k], flag_o[k], pulse_o[k]} == 5'b0,
             $sformatf("R11 reset outputs u%0d", k),
             int'({err_o[k], busy_o[k], done_o[k], flag_o[k], pulse_o[k]}), 0);
      end
      rst_n = 1;
      // functional compare, equal and single/multi-bit differences
      for (int i = 0; i < 24; i++) begin
         @(negedge clk);
         a = N'(i * 4099);
         b = (i % 3 == 0) ? a : (i % 3 == 1) ? (a ^ (N'(1) << (i % N))) : ~a;
      end
      @(negedge clk);
      chk(err_o[0] == 1, "R1 last difference seen", int'(err_o[0]), 1);
      // self-test with busy-time noise and ignored starts
      run_test(1'b1);
      // R8 clear
      @(negedge clk); clr = 1;
      @(negedge clk); clr = 0;
      chk(flag_o[1] == 0 && flag_o[2] == 0, "R8 clear", int'(flag_o[1]) + int'(flag_o[2]), 0);
      run_test(1'b0);
      // R8 reset clears flag
      @(negedge clk); rst_n = 0;
      @(negedge clk);
      chk(flag_o[1] == 0 && flag_o[2] == 0, "R8 reset clears", int'(flag_o[1]) + int'(flag_o[2]), 0);
      rst_n = 1;
      repeat (3) @(negedge clk);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: actual %0d expected %0d", 20000, 0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule